// File: doc/BRIEF.md
# Indexed codec control register file

This block is the host-facing control store of an audio codec. The host sees four byte-wide ports, picked by a two-bit select. Through them it reaches up to thirty-two 8-bit control registers by first writing an index and then reading or writing a data port. The block keeps every register at its reset value until the host changes it. It applies per-register write rules: read-only, reserved, single-bit-writable and write-masked registers. Writes to the sample-format register are allowed only while a mode-change enable is open.

The whole register image is driven out in parallel so the rest of the codec can use it. A playback-done event from the audio datapath sets an interrupt flag and a pending bit. A write to the status port clears both. When the host opens a mode change while calibration is armed, a short calibration-busy indication is raised. The host can then poll it through the error/status register.

Top module: `codecRegFile`

## Requirements
- R1: Port select 0 is the index port, 1 the indexed data port, 2 the status port and 3 the PIO data port. The index register resets to 0x40 (bit 6 = mode-change enable, MCE). A write stores the value with bit 7 forced to 0, so a read of port 0 never shows bit 7.
- R2: While bit 6 of register 12 (wide-index mode) is 0, the register number is index bits [3:0], so registers 16..31 cannot be reached. While it is 1, the register number is index bits [4:0].
- R3: Reset values are as follows. Registers 2, 3, 4, 5, 18 and 19 hold 0x88. Registers 6 and 7 hold 0x80. Register 9 holds 0x08 and register 12 holds 0x8A. Registers 25 and 26 hold 0xA0. Every other register holds 0x00.
- R4: A write to register 8 stores the whole byte when MCE is 1. When MCE is 0 and bit 4 of register 24 (partial enable) is 1, only bits [7:4] are updated and bits [3:0] keep their old value. Otherwise the write is dropped.
- R5: Register 11 cannot be written. Registers 22, 27 and 29 are reserved and ignore writes.
- R6: In register 12 only bit 6 can be written. Any value written to register 9 is stored with bit 5 cleared.
- R7: A port-0 write that moves MCE from 0 to 1 while register 9 bits [4:3] are not both zero loads a calibration counter with 1. While that counter is non-zero, a read of register 11 returns bit 5 set and the counter decrements by one.
- R8: A playback-done pulse sets the interrupt flag and bit 4 of register 24. A status-port write clears the interrupt flag and bits 6:4 of register 24. If both happen in the same cycle, the pulse wins for the bits it sets.
- R9: A status-port read returns the interrupt flag in bit 0 and zeros above it. Writes to the PIO port change nothing, and PIO port reads return 0x00.
- R10: Port reads return data combinationally in the cycle of the read strobe. A register write appears on the parallel image one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Direct port select |
| hostWrEn | input | 1 | One-cycle write strobe |
| hostRdEn | input | 1 | Read strobe; data valid in the same cycle |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data |
| evtPlayDone | input | 1 | Playback-done pulse from the datapath |
| regImage | output | 256 | All registers, register n at bits [8n+7:8n] |
| intFlag | output | 1 | Interrupt flag (status bit 0) |

## Verification
The index width is tried with the same index byte (0x50) in both modes. In narrow mode the write must land in register 0; in wide mode it must land in register 16. The format register is written under MCE open, under MCE closed with the partial enable off, and under MCE closed with it on. These three cases separate full, dropped and nibble-preserving writes. Calibration is tried in three ways: an MCE rising edge with arming bits set, a repeated MCE-high write, and an MCE rise with the arming bits cleared. Together they show that only an actual rise while armed loads the counter, and that each poll consumes one count. The interrupt flag is tried with the event alone, the clear alone, and both in the same cycle.

// File: rtl/codecRegPkg.sv
package codecRegPkg;
  localparam int NUM_REGS = 32;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int IMG_W    = NUM_REGS * DATA_W;

  // register numbers whose behaviour other logic relies on
  localparam int REG_FORMAT = 8;
  localparam int REG_IFACE  = 9;
  localparam int REG_ERRSTS = 11;
  localparam int REG_MODEID = 12;
  localparam int REG_ALTSTS = 24;

  localparam int MCE_BIT   = 6;
  localparam int WIDE_BIT  = 6;
  localparam int PART_BIT  = 4;
  localparam int CALIB_BIT = 5;

  typedef enum logic [2:0] {
    KIND_PLAIN, KIND_FIXED, KIND_FORMAT, KIND_IFACE, KIND_MODE, KIND_ALTSTS
  } regKind_e;

  typedef struct packed {
    logic             idxWr;
    logic             dataWr;
    logic             statWr;
    logic             calRd;
    logic [IDX_W-1:0] regIdx;
  } ctlStrobe_t;

  function automatic logic [DATA_W-1:0] resetValue(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: return 8'h88;
      6, 7:               return 8'h80;
      9:                  return 8'h08;
      12:                 return 8'h8A;
      25, 26:             return 8'hA0;
      default:            return 8'h00;
    endcase
  endfunction

  function automatic regKind_e kindOf(input int n);
    case (n)
      REG_FORMAT:           return KIND_FORMAT;
      REG_IFACE:            return KIND_IFACE;
      REG_ERRSTS, 22, 27, 29: return KIND_FIXED;
      REG_MODEID:           return KIND_MODE;
      REG_ALTSTS:           return KIND_ALTSTS;
      default:              return KIND_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/codecRegCtl.sv
module codecRegCtl
  import codecRegPkg::*;
#(
  parameter int CAL_W    = 2,
  parameter int CAL_LOAD = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              wideMode,
  input  logic [1:0]        calibArm,
  output ctlStrobe_t        strb,
  output logic [DATA_W-1:0] idxReg,
  output logic              calActive
);
  localparam logic [DATA_W-1:0] IDX_RESET = 8'h40;
  localparam logic [CAL_W-1:0]  CAL_INIT  = CAL_W'(CAL_LOAD);

  logic [CAL_W-1:0] calCnt;
  logic             mceRise;

  always_comb begin
    strb.idxWr  = hostWrEn && (hostSel == 2'd0);
    strb.dataWr = hostWrEn && (hostSel == 2'd1);
    strb.statWr = hostWrEn && (hostSel == 2'd2);
    strb.regIdx = wideMode ? idxReg[IDX_W-1:0] : {1'b0, idxReg[IDX_W-2:0]};
    strb.calRd  = hostRdEn && (hostSel == 2'd1) &&
                  (strb.regIdx == IDX_W'(REG_ERRSTS));
  end

  assign mceRise   = strb.idxWr && !idxReg[MCE_BIT] && hostWrData[MCE_BIT];
  assign calActive = (calCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= IDX_RESET;
    end else if (strb.idxWr) begin
      idxReg <= {1'b0, hostWrData[DATA_W-2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calCnt <= '0;
    end else if (mceRise && (calibArm != 2'b00)) begin
      calCnt <= CAL_INIT;
    end else if (strb.calRd && calActive) begin
      calCnt <= calCnt - 1'b1;
    end
  end
endmodule

// File: rtl/codecRegData.sv
module codecRegData
  import codecRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              evtPlayDone,
  input  logic [DATA_W-1:0] idxReg,
  input  logic              calActive,
  output logic [IMG_W-1:0]  regImage,
  output logic [DATA_W-1:0] hostRdData,
  output logic              intFlag,
  output logic              wideMode,
  output logic [1:0]        calibArm
);
  localparam logic [DATA_W-1:0] IFACE_MASK = ~(DATA_W'(1) << 5);
  localparam logic [DATA_W-1:0] PEND_MASK  = 8'h70;

  logic partEn;
  assign partEn = regImage[REG_ALTSTS*DATA_W + PART_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam regKind_e K = kindOf(g);
    localparam logic [DATA_W-1:0] RV = resetValue(g);
    logic hit;
    logic [DATA_W-1:0] q;
    assign hit = strb.dataWr && (strb.regIdx == IDX_W'(g));
    assign regImage[g*DATA_W +: DATA_W] = q;

    if (K == KIND_FIXED) begin : gFixed
      assign q = RV;
    end else if (K == KIND_FORMAT) begin : gFmt
      always_ff @(posedge clk) begin
        if (!rstN) q <= RV;
        else if (hit) begin
          if (idxReg[MCE_BIT]) q <= hostWrData;
          else if (partEn)     q <= {hostWrData[7:4], q[3:0]};
        end
      end
    end else if (K == KIND_IFACE) begin : gIface
      always_ff @(posedge clk) begin
        if (!rstN)    q <= RV;
        else if (hit) q <= hostWrData & IFACE_MASK;
      end
    end else if (K == KIND_MODE) begin : gMode
      always_ff @(posedge clk) begin
        if (!rstN)    q <= RV;
        else if (hit) q[WIDE_BIT] <= hostWrData[WIDE_BIT];
      end
    end else if (K == KIND_ALTSTS) begin : gAlt
      logic [DATA_W-1:0] nxt;
      always_comb begin
        nxt = q;
        if (hit)         nxt = hostWrData;
        if (strb.statWr) nxt = nxt & ~PEND_MASK;
        if (evtPlayDone) nxt[PART_BIT] = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!rstN) q <= RV;
        else       q <= nxt;
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (!rstN)    q <= RV;
        else if (hit) q <= hostWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            intFlag <= 1'b0;
    else if (evtPlayDone) intFlag <= 1'b1;
    else if (strb.statWr) intFlag <= 1'b0;
  end

  assign wideMode = regImage[REG_MODEID*DATA_W + WIDE_BIT];
  assign calibArm = regImage[REG_IFACE*DATA_W + 3 +: 2];

  logic [DATA_W-1:0] selReg;
  assign selReg = regImage[strb.regIdx*DATA_W +: DATA_W];

  always_comb begin
    case (hostSel)
      2'd0: hostRdData = {1'b0, idxReg[DATA_W-2:0]};
      2'd1: begin
        hostRdData = selReg;
        if (strb.regIdx == IDX_W'(REG_ERRSTS) && calActive)
          hostRdData[CALIB_BIT] = 1'b1;
      end
      2'd2:    hostRdData = {{(DATA_W-1){1'b0}}, intFlag};
      default: hostRdData = '0;
    endcase
  end
endmodule

// File: rtl/codecRegFile.sv
module codecRegFile
  import codecRegPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       hostSel,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic [7:0]       hostWrData,
  output logic [7:0]       hostRdData,
  input  logic             evtPlayDone,
  output logic [255:0]     regImage,
  output logic             intFlag
);
  ctlStrobe_t        strb;
  logic [DATA_W-1:0] idxReg;
  logic              calActive;
  logic              wideMode;
  logic [1:0]        calibArm;

  codecRegCtl #(.CAL_W(2), .CAL_LOAD(1)) ctl_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .wideMode(wideMode),
    .calibArm(calibArm), .strb(strb), .idxReg(idxReg), .calActive(calActive)
  );

  codecRegData data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSel(hostSel),
    .hostWrData(hostWrData), .evtPlayDone(evtPlayDone), .idxReg(idxReg),
    .calActive(calActive), .regImage(regImage), .hostRdData(hostRdData),
    .intFlag(intFlag), .wideMode(wideMode), .calibArm(calibArm)
  );
endmodule

// File: rtl/codecRegFileChk.sv
module codecRegFileChk (
  input logic         clk,
  input logic         rstN,
  input logic [1:0]   hostSel,
  input logic         hostWrEn,
  input logic         hostRdEn,
  input logic [7:0]   hostRdData,
  input logic         evtPlayDone,
  input logic [255:0] regImage,
  input logic         intFlag,
  input logic [7:0]   idxReg
);
  // R1: index port never shows bit 7
  assert_idx_bit7_R1: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostSel == 2'd0) |-> (hostRdData[7] == 1'b0));

  // R4: with MCE closed the low nibble of the format register holds
  assert_fmt_nibble_R4: assert property (@(posedge clk) disable iff (!rstN)
    !idxReg[6] |=> (regImage[67:64] == $past(regImage[67:64])));

  // R5: reserved registers and the read-only register never move
  assert_fixed_regs_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(regImage[95:88]) && $stable(regImage[183:176]) &&
              $stable(regImage[223:216]) && $stable(regImage[239:232])));

  // R6: only bit 6 of register 12 may change
  assert_mode_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($stable(regImage[101:96]) && $stable(regImage[103])));

  // R8: a status write without an event clears the flag
  assert_int_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostSel == 2'd2 && !evtPlayDone) |=> !intFlag);

  // R9: PIO port reads as zero
  assert_pio_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostSel == 2'd3) |-> (hostRdData == 8'h00));
endmodule

bind codecRegFile codecRegFileChk chk_i (.*);

// File: tb/codecRegFile_tb_top.sv
module codecRegFile_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [1:0]   hostSel = 2'd0;
  logic         hostWrEn = 1'b0;
  logic         hostRdEn = 1'b0;
  logic [7:0]   hostWrData = 8'h00;
  logic [7:0]   hostRdData;
  logic         evtPlayDone = 1'b0;
  logic [255:0] regImage;
  logic         intFlag;

  int testCount = 0;
  int failCount = 0;
  logic [7:0] expReg [32];
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  codecRegFile dut_i (.*);

  function automatic logic [7:0] rstVal(input int n);
    if (n >= 2 && n <= 5) return 8'h88;
    if (n == 18 || n == 19) return 8'h88;
    if (n == 6 || n == 7) return 8'h80;
    if (n == 9) return 8'h08;
    if (n == 12) return 8'h8A;
    if (n == 25 || n == 26) return 8'hA0;
    return 8'h00;
  endfunction

  task automatic hostWrite(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    hostSel = s; hostWrData = d; hostWrEn = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] d);
    hostWrite(2'd0, idx);
    hostWrite(2'd1, d);
  endtask

  // driver: queue the expectation, then strobe the read
  task automatic hostRead(input logic [1:0] s, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back(e); tagQ.push_back(tag);
    hostSel = s; hostRdEn = 1'b1;
    @(posedge clk); #1;
    hostRdEn = 1'b0;
  endtask

  // monitor: compare read data mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (hostRdEn && expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        testCount++;
        if (hostRdData !== e) begin
          failCount++;
          $display("FAIL %s read got %02h expected %02h", t, hostRdData, e);
        end
      end
    end
  end

  task automatic checkImage(input string tag);
    logic [255:0] e;
    @(negedge clk);
    for (int i = 0; i < 32; i++) e[i*8 +: 8] = expReg[i];
    testCount++;
    if (regImage !== e) begin
      failCount++;
      $display("FAIL %s image got %h expected %h", tag, regImage, e);
    end
  endtask

  task automatic checkInt(input logic e, input string tag);
    @(negedge clk);
    testCount++;
    if (intFlag !== e) begin
      failCount++;
      $display("FAIL %s intFlag got %0b expected %0b", tag, intFlag, e);
    end
  endtask

  initial begin
    #200000;
    failCount++;
    testCount++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) expReg[i] = rstVal(i);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 R3 reset state
    hostRead(2'd0, 8'h40, "R1 index reset");
    checkImage("R3 reset values");

    // R2 narrow mode: 0x50 reaches register 0
    regWrite(8'h50, 8'h55); expReg[0] = 8'h55;
    checkImage("R2 narrow no alias");
    hostRead(2'd1, 8'h55, "R2 narrow readback");

    // R6 mode register: only bit 6
    regWrite(8'h4C, 8'h05);
    checkImage("R6 mode ignores other bits");
    hostWrite(2'd1, 8'hFF); expReg[12] = 8'hCA;
    checkImage("R6 mode bit set");

    // R2 wide mode: 0x50 reaches register 16
    regWrite(8'h50, 8'h33); expReg[16] = 8'h33;
    hostRead(2'd1, 8'h33, "R2 wide readback");
    checkImage("R2 wide image");

    // R4 format gating
    regWrite(8'h48, 8'hAB); expReg[8] = 8'hAB;
    checkImage("R4 full write MCE");
    regWrite(8'h08, 8'h11);
    checkImage("R4 dropped write");
    regWrite(8'h18, 8'h10); expReg[24] = 8'h10;
    regWrite(8'h08, 8'h5F); expReg[8] = 8'h5B;
    checkImage("R4 partial nibble kept");

    // R6 reg9 bit 5 cleared (MCE rise here arms counter: reg9 was 0x08)
    regWrite(8'h49, 8'hFF); expReg[9] = 8'hDF;
    checkImage("R6 iface bit5");

    // R7 calibration
    hostWrite(2'd0, 8'h4B);
    hostRead(2'd1, 8'h20, "R7 first poll busy");
    hostRead(2'd1, 8'h00, "R7 second poll idle");
    hostWrite(2'd1, 8'hFF);
    hostRead(2'd1, 8'h00, "R5 read-only reg11");
    hostWrite(2'd0, 8'h0B);
    hostWrite(2'd0, 8'h4B);
    hostRead(2'd1, 8'h20, "R7 reload on rise");
    hostWrite(2'd0, 8'h4B);
    hostRead(2'd1, 8'h00, "R7 no reload without rise");
    regWrite(8'h49, 8'h00); expReg[9] = 8'h00;
    hostWrite(2'd0, 8'h0B);
    hostWrite(2'd0, 8'h4B);
    hostRead(2'd1, 8'h00, "R7 unarmed rise");

    // R5 reserved
    regWrite(8'h56, 8'hFF);
    hostRead(2'd1, 8'h00, "R5 reserved 22");
    regWrite(8'h5B, 8'h77);
    regWrite(8'h5D, 8'h66);
    checkImage("R5 reserved image");

    // R8 event and status clear
    regWrite(8'h58, 8'hE0); expReg[24] = 8'hE0;
    checkInt(1'b0, "R8 idle flag");
    @(posedge clk); #1 evtPlayDone = 1'b1;
    @(posedge clk); #1 evtPlayDone = 1'b0;
    expReg[24] = 8'hF0;
    checkInt(1'b1, "R8 event sets flag");
    checkImage("R8 event sets pending");
    hostRead(2'd2, 8'h01, "R9 status read");
    hostWrite(2'd2, 8'h00); expReg[24] = 8'h80;
    checkInt(1'b0, "R8 status clears flag");
    checkImage("R8 status clears pending");
    @(posedge clk); #1;
    hostSel = 2'd2; hostWrEn = 1'b1; evtPlayDone = 1'b1;
    @(posedge clk); #1;
    hostWrEn = 1'b0; evtPlayDone = 1'b0;
    expReg[24] = 8'h90;
    checkInt(1'b1, "R8 event wins");
    checkImage("R8 event wins pending");

    // R9 PIO ignored
    hostWrite(2'd3, 8'hFF);
    checkImage("R9 PIO write ignored");
    checkInt(1'b1, "R9 PIO keeps flag");
    hostRead(2'd3, 8'h00, "R9 PIO read");

    // R1 R10 bit 7 dropped
    hostWrite(2'd0, 8'hFF);
    hostRead(2'd0, 8'h7F, "R1 bit7 dropped");
    hostWrite(2'd1, 8'hC3); expReg[31] = 8'hC3;
    checkImage("R10 image after one clock");

    repeat (3) @(posedge clk);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule